// File: doc/BRIEF.md
# Two-Way Set-Associative Read Cache

This block is a small load-side cache placed between a processor's load port and a slower backing memory that returns whole 32-bit words. It holds eight one-word lines, organised as four sets with two ways each. A load is looked up in both ways of its set at once. On a hit the stored word comes back without touching the backing memory. On a miss the block asks the backing memory for the aligned word. It waits for the reply and writes the word into one way of the set. Then it hands the word to the processor.

Each set has a single recency bit, and this bit chooses the way to overwrite when both ways are occupied. A way that is still empty is always filled before an occupied one. Two free-running counters report how many lookups hit and how many missed, so a loop of accesses can be scored by its miss count.

The processor side uses a ready/pulse protocol. A request is accepted only while `ld_ready` is high. The result appears together with a one-cycle `ld_done` pulse. The backing memory side uses a request that is held high until a one-cycle valid strobe comes back.

Top module: `assoc2_read_cache`

## Requirements
- R1: After reset `ld_ready` is 1, `ld_done` is 0, both counters are 0 and every line is empty, so the first load of any address misses.
- R2: Address bits [1:0] select a byte and take no part in the lookup. Bits [3:2] pick the set and bits [31:4] are the tag. Loading 0x107 after 0x104 therefore hits and returns the same word.
- R3: A hit raises `ld_done` two falling edges after the request was driven, returns the cached word and does not raise `mem_req`. The cached word is returned even if the backing memory has since changed.
- R4: A miss holds `ld_ready` low, raises `mem_req` with `mem_addr` equal to the load address with bits [1:0] cleared, and keeps both stable until `mem_valid`. `ld_done` rises with the memory word on the edge after `mem_valid` is seen.
- R5: Two addresses that share a set but differ in tag (0x04 and 0x24, both set 1) both stay resident. Looping over them five times gives 2 misses and 8 hits.
- R6: A fill goes into an empty way of the set when there is one, and way 0 is used when both ways are empty.
- R7: When both ways of the set are valid, a miss replaces the way that was used least recently. Loading 0x04, then 0x24, then 0x54 evicts 0x04. If 0x04 is reused before 0x54 arrives, 0x24 is evicted instead.
- R8: Every accepted lookup adds exactly one to either `hit_count` or `miss_count`. Looping five times over 0x4, 0xC and 0x8 gives 3 misses and 12 hits.
- R9: A request raised while `ld_ready` is low is ignored. It starts no lookup, changes no counter and does not alter the load in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_req | input | 1 | Load request, accepted while ld_ready is high |
| ld_addr | input | 32 | Byte address of the load |
| ld_ready | output | 1 | High when a new load can be accepted |
| ld_done | output | 1 | One-cycle pulse marking ld_data valid |
| ld_data | output | 32 | Returned load word |
| mem_req | output | 1 | Word fetch request to backing memory, held until mem_valid |
| mem_addr | output | 32 | Word-aligned fetch address |
| mem_valid | input | 1 | Backing memory strobe, mem_data valid |
| mem_data | input | 32 | Word from backing memory |
| hit_count | output | 16 | Number of lookups that hit |
| miss_count | output | 16 | Number of lookups that missed |

## Verification
The bench targets replacement order within a single set.

- A design that always replaces way 0, or that ignores the recency bit, fails the 0x04/0x24/0x54 sequences. There it evicts the wrong line, so a later reload that should hit misses, or the reverse.
- A design that folds the byte offset into the tag or index misses on 0x107.
- A design that skips the tag compare serves 0x24 from 0x04's line and returns the wrong word.
- Changing the backing memory after a fill shows whether hits really come from the cache.
- A request driven during an outstanding fetch shows whether a busy design starts a second, spurious lookup.

// File: rtl/rc_pkg.sv
package rc_pkg;
   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_LOOKUP = 2'd1,
      ST_FETCH  = 2'd2
   } rc_state_t;
endpackage

// File: rtl/rc_way_bank.sv
module rc_way_bank #(
   parameter int SETS   = 4,
   parameter int TAG_W  = 28,
   parameter int DATA_W = 32,
   localparam int IDX_W = (SETS > 1) ? $clog2(SETS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [IDX_W-1:0]  rd_idx,
   input  logic [TAG_W-1:0]  cmp_tag,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [TAG_W-1:0]  wr_tag,
   input  logic [DATA_W-1:0] wr_data,
   output logic              hit,
   output logic              line_valid,
   output logic [DATA_W-1:0] line_data
);
   logic [SETS-1:0]   valid_q;
   logic [TAG_W-1:0]  tag_q  [SETS];
   logic [DATA_W-1:0] data_q [SETS];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q <= '0;
      end else if (wr_en) begin
         valid_q[wr_idx] <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (wr_en) begin
         tag_q[wr_idx]  <= wr_tag;
         data_q[wr_idx] <= wr_data;
      end
   end

   assign line_valid = valid_q[rd_idx];
   assign line_data  = data_q[rd_idx];
   assign hit        = line_valid && (tag_q[rd_idx] == cmp_tag);
endmodule

// File: rtl/rc_lru_bits.sv
module rc_lru_bits #(
   parameter int SETS = 4,
   localparam int IDX_W = (SETS > 1) ? $clog2(SETS) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] rd_idx,
   output logic             lru_way,
   input  logic             upd_en,
   input  logic [IDX_W-1:0] upd_idx,
   input  logic             upd_way
);
   logic [SETS-1:0] older_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         older_q <= '0;
      end else if (upd_en) begin
         older_q[upd_idx] <= ~upd_way;
      end
   end

   assign lru_way = older_q[rd_idx];

   // R7: the way just touched is never the one marked for eviction next
   a_r7_lru_flips_away: assert property (@(posedge clk) disable iff (!rst_n)
      upd_en |=> (older_q[$past(upd_idx)] != $past(upd_way)));
endmodule

// File: rtl/rc_ctrl.sv
module rc_ctrl
   import rc_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ld_req,
   input  logic             any_hit,
   input  logic             mem_valid,
   output rc_state_t        state,
   output logic             cap_en,
   output logic             lookup_hit,
   output logic             fill_en,
   output logic             done_q,
   output logic [CNT_W-1:0] hit_cnt,
   output logic [CNT_W-1:0] miss_cnt
);
   rc_state_t        st_q, st_d;
   logic [CNT_W-1:0] tot;

   assign cap_en     = (st_q == ST_IDLE) && ld_req;
   assign lookup_hit = (st_q == ST_LOOKUP) && any_hit;
   assign fill_en    = (st_q == ST_FETCH) && mem_valid;
   assign state      = st_q;
   assign tot        = hit_cnt + miss_cnt;

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         ST_IDLE:   if (ld_req) st_d = ST_LOOKUP;
         ST_LOOKUP: st_d = any_hit ? ST_IDLE : ST_FETCH;
         ST_FETCH:  if (mem_valid) st_d = ST_IDLE;
         default:   st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q     <= ST_IDLE;
         done_q   <= 1'b0;
         hit_cnt  <= '0;
         miss_cnt <= '0;
      end else begin
         st_q   <= st_d;
         done_q <= lookup_hit || fill_en;
         if (st_q == ST_LOOKUP) begin
            if (any_hit) hit_cnt  <= hit_cnt + 1'b1;
            else         miss_cnt <= miss_cnt + 1'b1;
         end
      end
   end

   // R3: a hit completes without entering the fetch state
   a_r3_hit_skips_fetch: assert property (@(posedge clk) disable iff (!rst_n)
      lookup_hit |=> (st_q == ST_IDLE) && done_q);

   // R8: each lookup moves the combined count by exactly one
   a_r8_one_count_per_lookup: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_LOOKUP) |=> (tot == CNT_W'($past(tot) + 1'b1)));

   // R9: nothing counts while no lookup is in progress
   a_r9_idle_counts_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q != ST_LOOKUP) |=> $stable(tot));
endmodule

// File: rtl/assoc2_read_cache.sv
module assoc2_read_cache
   import rc_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32,
   parameter int SETS   = 4,
   parameter int CNT_W  = 16,
   localparam int WAYS  = 2,
   localparam int OFF_W = $clog2(DATA_W / 8),
   localparam int IDX_W = (SETS > 1) ? $clog2(SETS) : 1,
   localparam int TAG_W = ADDR_W - IDX_W - OFF_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld_req,
   input  logic [ADDR_W-1:0] ld_addr,
   output logic              ld_ready,
   output logic              ld_done,
   output logic [DATA_W-1:0] ld_data,
   output logic              mem_req,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic              mem_valid,
   input  logic [DATA_W-1:0] mem_data,
   output logic [CNT_W-1:0]  hit_count,
   output logic [CNT_W-1:0]  miss_count
);
   if (DATA_W < 8 || (DATA_W & (DATA_W - 1)) != 0) begin : g_bad_data_w
      $error("DATA_W must be a power of two of at least 8");
   end
   if (SETS < 2 || (SETS & (SETS - 1)) != 0) begin : g_bad_sets
      $error("SETS must be a power of two of at least 2");
   end
   if (TAG_W < 1) begin : g_bad_tag
      $error("address too narrow for the chosen geometry");
   end
   if (CNT_W < 2) begin : g_bad_cnt
      $error("CNT_W must be at least 2");
   end

   rc_state_t         state;
   logic              cap_en, lookup_hit, fill_en;
   logic [ADDR_W-1:0] addr_q;
   logic [IDX_W-1:0]  set_idx;
   logic [TAG_W-1:0]  addr_tag;
   logic [WAYS-1:0]   way_hit, way_valid, way_wr;
   logic [DATA_W-1:0] way_data [WAYS];
   logic [DATA_W-1:0] sel_data, rd_data_q;
   logic              any_hit, lru_way, victim, upd_way;

   always_ff @(posedge clk) begin
      if (!rst_n)      addr_q <= '0;
      else if (cap_en) addr_q <= ld_addr;
   end

   assign set_idx  = addr_q[OFF_W +: IDX_W];
   assign addr_tag = addr_q[ADDR_W-1 -: TAG_W];

   for (genvar w = 0; w < WAYS; w++) begin : g_way
      assign way_wr[w] = fill_en && (victim == 1'(w));
      rc_way_bank #(
         .SETS   (SETS),
         .TAG_W  (TAG_W),
         .DATA_W (DATA_W)
      ) u_bank (
         .clk        (clk),
         .rst_n      (rst_n),
         .rd_idx     (set_idx),
         .cmp_tag    (addr_tag),
         .wr_en      (way_wr[w]),
         .wr_idx     (set_idx),
         .wr_tag     (addr_tag),
         .wr_data    (mem_data),
         .hit        (way_hit[w]),
         .line_valid (way_valid[w]),
         .line_data  (way_data[w])
      );
   end

   always_comb begin
      sel_data = '0;
      for (int w = 0; w < WAYS; w++) begin
         sel_data = sel_data | ({DATA_W{way_hit[w]}} & way_data[w]);
      end
   end
   assign any_hit = |way_hit;

   rc_lru_bits #(.SETS(SETS)) u_lru (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_idx  (set_idx),
      .lru_way (lru_way),
      .upd_en  (lookup_hit || fill_en),
      .upd_idx (set_idx),
      .upd_way (upd_way)
   );

   always_comb begin
      if (!way_valid[0])      victim = 1'b0;
      else if (!way_valid[1]) victim = 1'b1;
      else                    victim = lru_way;
   end
   assign upd_way = lookup_hit ? way_hit[1] : victim;

   rc_ctrl #(.CNT_W(CNT_W)) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .ld_req     (ld_req),
      .any_hit    (any_hit),
      .mem_valid  (mem_valid),
      .state      (state),
      .cap_en     (cap_en),
      .lookup_hit (lookup_hit),
      .fill_en    (fill_en),
      .done_q     (ld_done),
      .hit_cnt    (hit_count),
      .miss_cnt   (miss_count)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)          rd_data_q <= '0;
      else if (lookup_hit) rd_data_q <= sel_data;
      else if (fill_en)    rd_data_q <= mem_data;
   end

   assign ld_data  = rd_data_q;
   assign ld_ready = (state == ST_IDLE);
   assign mem_req  = (state == ST_FETCH);
   assign mem_addr = {addr_q[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};

   // R5: one line per tag in a set, so at most one way can match
   a_r5_single_way_hit: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(way_hit));

   // R6: a fill into a set with an empty way grows its occupancy by one
   a_r6_empty_way_first: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_en && !(&way_valid)) |=>
         ($countones(way_valid) == $countones($past(way_valid)) + 1));

   // R4: the fetch request and its address hold until the memory answers
   a_r4_fetch_held: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_valid) |=> (mem_req && $stable(mem_addr) && !ld_ready));
endmodule

// File: tb/tb_assoc2_read_cache.sv
module tb_assoc2_read_cache;
   localparam int CLK_PERIOD = 10;
   localparam int MEM_LAT    = 3;
   localparam int WD_CYCLES  = 100000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ld_req = 1'b0;
   logic [31:0] ld_addr = '0;
   logic        ld_ready, ld_done;
   logic [31:0] ld_data;
   logic        mem_req;
   logic [31:0] mem_addr;
   logic        mem_valid = 1'b0;
   logic [31:0] mem_data = '0;
   logic [15:0] hit_count, miss_count;

   int          n_vec = 0;
   int          n_bad = 0;
   logic [31:0] salt = '0;
   logic [31:0] last_fetch = '0;
   bit          fetch_misaligned = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   assoc2_read_cache dut (
      .clk(clk), .rst_n(rst_n), .ld_req(ld_req), .ld_addr(ld_addr),
      .ld_ready(ld_ready), .ld_done(ld_done), .ld_data(ld_data),
      .mem_req(mem_req), .mem_addr(mem_addr), .mem_valid(mem_valid),
      .mem_data(mem_data), .hit_count(hit_count), .miss_count(miss_count)
   );

   function automatic logic [31:0] word_at(input logic [31:0] a, input logic [31:0] s);
      return {a[31:2], 2'b00} ^ 32'h5A3C_0000 ^ s;
   endfunction

   // behavioural backing memory, acts on falling edges
   initial begin
      int wait_n = 0;
      forever begin
         @(negedge clk);
         if (mem_valid) begin
            mem_valid = 1'b0;
            wait_n = 0;
         end else if (mem_req) begin
            wait_n++;
            if (wait_n == MEM_LAT) begin
               last_fetch = mem_addr;
               if (mem_addr[1:0] != 2'b00) fetch_misaligned = 1'b1;
               mem_data  = word_at(mem_addr, salt);
               mem_valid = 1'b1;
            end
         end
      end
   end

   task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
      n_vec++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=0x%08h expected=0x%08h", rq, act, exp);
      end
   endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; ld_req = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic do_load(input logic [31:0] a, output logic [31:0] d,
                          output int lat, output bit was_hit, output bit busy_ok);
      logic [15:0] m0;
      @(negedge clk);
      while (!ld_ready) @(negedge clk);
      m0 = miss_count;
      ld_addr = a; ld_req = 1'b1;
      @(negedge clk);
      ld_req = 1'b0; lat = 1; busy_ok = 1'b1;
      while (!ld_done && lat < 1000) begin
         if (ld_ready) busy_ok = 1'b0;
         @(negedge clk);
         lat++;
      end
      d = ld_data;
      was_hit = (miss_count == m0);
   endtask

   task automatic expect_load(input logic [31:0] a, input bit exp_hit, input string rq);
      logic [31:0] d; int lat; bit h; bit b;
      do_load(a, d, lat, h, b);
      chk(h == exp_hit, rq, 32'(h), 32'(exp_hit));
      chk(d == word_at(a, salt), rq, d, word_at(a, salt));
   endtask

   task automatic t_reset_state();
      do_reset();
      @(negedge clk);
      chk(ld_ready == 1'b1, "R1 ready", 32'(ld_ready), 32'd1);
      chk(ld_done == 1'b0, "R1 done", 32'(ld_done), 32'd0);
      chk(hit_count == 0 && miss_count == 0, "R1 counters",
          {hit_count, miss_count}, 32'd0);
      expect_load(32'h0000_0040, 1'b0, "R1 first load misses");
   endtask

   task automatic t_offset_split();
      do_reset();
      expect_load(32'h0000_0104, 1'b0, "R2 cold");
      expect_load(32'h0000_0107, 1'b1, "R2 byte offset ignored");
      expect_load(32'h0000_0100, 1'b0, "R2 other set");
      expect_load(32'h0000_0114, 1'b0, "R2 tag differs");
   endtask

   task automatic t_hit_latency_and_stale();
      logic [31:0] d, first; int lat; bit h; bit b;
      do_reset();
      do_load(32'h0000_0208, first, lat, h, b);
      chk(lat > 2, "R4 miss latency", 32'(lat), 32'd3);
      chk(b, "R4 ready low while busy", 32'(b), 32'd1);
      chk(last_fetch == 32'h0000_0208 && !fetch_misaligned, "R4 fetch address",
          last_fetch, 32'h0000_0208);
      salt = 32'h0000_1111;
      do_load(32'h0000_020A, d, lat, h, b);
      chk(lat == 2, "R3 hit latency", 32'(lat), 32'd2);
      chk(d == first, "R3 stale cached word", d, first);
      salt = '0;
   endtask

   task automatic t_same_block_loop();
      do_reset();
      for (int i = 0; i < 5; i++) begin
         expect_load(32'h4, i != 0, "R8 loop 0x4");
         expect_load(32'hC, i != 0, "R8 loop 0xC");
         expect_load(32'h8, i != 0, "R8 loop 0x8");
      end
      chk(miss_count == 3, "R8 miss count", 32'(miss_count), 32'd3);
      chk(hit_count == 12, "R8 hit count", 32'(hit_count), 32'd12);
   endtask

   task automatic t_conflict_pair();
      do_reset();
      for (int i = 0; i < 5; i++) begin
         expect_load(32'h04, i != 0, "R5 pair 0x04");
         expect_load(32'h24, i != 0, "R5 pair 0x24");
      end
      chk(miss_count == 2, "R5 miss count", 32'(miss_count), 32'd2);
      chk(hit_count == 8, "R5 hit count", 32'(hit_count), 32'd8);
   endtask

   task automatic t_lru_plain();
      do_reset();
      expect_load(32'h04, 1'b0, "R6 fill first empty way");
      expect_load(32'h24, 1'b0, "R6 fill second empty way");
      expect_load(32'h04, 1'b1, "R6 both resident");
      expect_load(32'h54, 1'b0, "R7 third tag");
      expect_load(32'h04, 1'b1, "R7 recent line kept");
      expect_load(32'h24, 1'b0, "R7 oldest evicted");
   endtask

   task automatic t_lru_order();
      do_reset();
      expect_load(32'h04, 1'b0, "R7 order fill a");
      expect_load(32'h24, 1'b0, "R7 order fill b");
      expect_load(32'h54, 1'b0, "R7 order fill c");
      expect_load(32'h24, 1'b1, "R7 order b kept");
      expect_load(32'h04, 1'b0, "R7 order a evicted");
      expect_load(32'h24, 1'b1, "R7 order b still kept");
      expect_load(32'h54, 1'b0, "R7 order c evicted");
   endtask

   task automatic t_busy_ignored();
      do_reset();
      @(negedge clk);
      ld_addr = 32'h0000_0080; ld_req = 1'b1;
      @(negedge clk);
      ld_req = 1'b0;
      @(negedge clk);
      ld_addr = 32'h0000_0090; ld_req = 1'b1;
      @(negedge clk);
      ld_req = 1'b0;
      while (!ld_done) @(negedge clk);
      chk(ld_data == word_at(32'h80, salt), "R9 load in progress intact",
          ld_data, word_at(32'h80, salt));
      repeat (4) @(negedge clk);
      chk(ld_ready == 1'b1, "R9 back to ready", 32'(ld_ready), 32'd1);
      chk(miss_count == 1 && hit_count == 0, "R9 no extra lookup",
          {hit_count, miss_count}, 32'd1);
   endtask

   initial begin
      repeat (WD_CYCLES) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      summary();
      $finish;
   end

   initial begin
      t_reset_state();
      t_offset_split();
      t_hit_latency_and_stale();
      t_same_block_loop();
      t_conflict_pair();
      t_lru_plain();
      t_lru_order();
      t_busy_ignored();
      repeat (2) @(negedge clk);
      summary();
      $finish;
   end
endmodule